// File: doc/BRIEF.md
# Four-Bit Indirect Register Bus Interface

This block is the slave side of a narrow microprocessor port that controls four powered lines. A host reaches it through a four-bit data bus, one address bit, an address-latch strobe, a chip select and separate active-low read and write strobes. Two registers can be written. The first is a group selector, which also carries an interrupt-enable bit. The second is a per-line turn-on request register. The design has a single data pin set, so the bus appears as separate input, output and output-enable vectors, and the pad ring builds the tristate driver from them.

With the address bit low, a read returns the group selector together with a chip over-temperature flag. With the address bit high, a read returns one of six four-bit status groups, chosen by the selector code. Those groups are power-on phase, open loop, overload, active enable, the request register itself, and per-line thermal overload. An active-low interrupt output follows the overload flags whenever the interrupt is enabled. It holds no memory of past events.

All bus pins arrive asynchronously. They are brought into the system clock domain through two-flop synchronisers. A write takes effect when its access ends, which is the first rise of either the write strobe or the chip select.

Top module: `ifb_regport`

## Requirements
- R1: After reset the request register and the selector read 0, the interrupt is disabled, `int_n` is high and `dq_oe` is low.
- R2: A write with address 0 stores data bits 2..0 as the selector and data bit 3 as the interrupt enable. It takes effect at the first rise of `wr_n` or `cs_n` that ends the access, so a write ended by `cs_n` rising first still commits.
- R3: A write with address 1 stores data bits 3..0 into the request register, where bit n is the turn-on request for line n (1 = on). The register drives `req_en`.
- R4: A read with address 0 returns the over-temperature flag `hot` on bit 3 and the selector on bits 2..0. It does not return the stored interrupt enable.
- R5: A read with address 1 returns the status group chosen by the selector code: 000 power-on phase, 001 open loop, 010 overload, 011 active enable, 110 request register, 111 thermal overload, with line n on bit n.
- R6: The reserved selector codes 100 and 101 read back as 0000.
- R7: The bus is driven (`dq_oe` high) only while `cs_n` and `rd_n` are both low, after the two-clock synchroniser delay. Otherwise it is released.
- R8: The address bit passes straight through while `ale` is high and is captured when `ale` falls. While `ale` is low, later changes of `a0` are ignored.
- R9: `int_n` is low exactly when the interrupt is enabled and at least one overload bit is high, one clock after the inputs settle. It returns high as soon as all overload bits clear and holds no history.
- R10: Write-strobe activity while `cs_n` is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, transparent while high |
| a0 | input | 1 | Register address bit |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dq_in | input | 4 | Data bus value seen at the pins |
| dq_out | output | 4 | Read data driven onto the bus |
| dq_oe | output | 1 | Bus output enable |
| hot | input | 1 | Chip over-temperature flag |
| st_pwr | input | 4 | Per-line power-on phase |
| st_open | input | 4 | Per-line open-loop flag |
| st_ovl | input | 4 | Per-line overload flag |
| st_act | input | 4 | Per-line active enable from the control logic |
| st_therm | input | 4 | Per-line thermal overload |
| req_en | output | 4 | Per-line turn-on request register |
| int_n | output | 1 | Interrupt, active low |

## Verification
A wrong selector value shows on the next read with address 0. It also shows on every read with address 1, because the wrong status group comes back. A corrupted or missed commit shows on `req_en` within three clocks of the strobe that ended the access. A mis-latched address bit returns the wrong kind of data on the next read. A stuck or wrongly stored interrupt enable shows on `int_n` one clock after the overload bits change.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int NUM_LINES = 4;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    GRP_PWR   = 3'b000,
    GRP_OPEN  = 3'b001,
    GRP_OVL   = 3'b010,
    GRP_ACT   = 3'b011,
    GRP_RSV4  = 3'b100,
    GRP_RSV5  = 3'b101,
    GRP_REQ   = 3'b110,
    GRP_THERM = 3'b111
  } grp_e;
endpackage

// File: rtl/ifb_sync.sv
module ifb_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ifb_rst_sync.sv
module ifb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) rs_q <= 2'b00;
    else           rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_out = rs_q[1];
endmodule

// File: rtl/ifb_decode.sv
module ifb_decode
  import ifb_pkg::*;
#(
  parameter int NL = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale_s,
  input  logic             a0_s,
  input  logic             cs_n_s,
  input  logic             rd_n_s,
  input  logic             wr_n_s,
  input  logic [NL-1:0]    d_s,
  output logic             addr_eff,
  output logic             rd_act,
  output logic [SEL_W-1:0] sel_q,
  output logic             int_en_q,
  output logic [NL-1:0]    req_q
);
  logic             a0_lat_q, a0_lat_d;
  logic             wr_act, wr_act_q, commit;
  logic             hold_a_q, hold_a_d;
  logic [NL-1:0]    hold_d_q, hold_d_d;
  logic [SEL_W-1:0] sel_d;
  logic             int_en_d;
  logic [NL-1:0]    req_d;

  always_comb begin
    addr_eff = ale_s ? a0_s : a0_lat_q;
    a0_lat_d = addr_eff;
    wr_act   = !cs_n_s && !wr_n_s;
    rd_act   = !cs_n_s && !rd_n_s;
    commit   = wr_act_q && !wr_act;
    hold_a_d = wr_act ? addr_eff : hold_a_q;
    hold_d_d = wr_act ? d_s : hold_d_q;
    sel_d    = sel_q;
    int_en_d = int_en_q;
    req_d    = req_q;
    if (commit) begin
      if (hold_a_q) begin
        req_d = hold_d_q;
      end else begin
        sel_d    = hold_d_q[SEL_W-1:0];
        int_en_d = hold_d_q[NL-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_lat_q <= 1'b0;
      wr_act_q <= 1'b0;
      hold_a_q <= 1'b0;
      hold_d_q <= '0;
      sel_q    <= '0;
      int_en_q <= 1'b0;
      req_q    <= '0;
    end else begin
      a0_lat_q <= a0_lat_d;
      wr_act_q <= wr_act;
      hold_a_q <= hold_a_d;
      hold_d_q <= hold_d_d;
      sel_q    <= sel_d;
      int_en_q <= int_en_d;
      req_q    <= req_d;
    end
  end

  // R10: with chip select high for two cycles, no register moves
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |=> ($stable(req_q) && $stable(sel_q) && $stable(int_en_q)));

  // R8: with ALE low, the effective address cannot change
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && $past(!ale_s)) |-> $stable(addr_eff));
endmodule

// File: rtl/ifb_rdmux.sv
module ifb_rdmux
  import ifb_pkg::*;
#(
  parameter int NL = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic [SEL_W-1:0] sel,
  input  logic             hot,
  input  logic [NL-1:0]    st_pwr,
  input  logic [NL-1:0]    st_open,
  input  logic [NL-1:0]    st_ovl,
  input  logic [NL-1:0]    st_act,
  input  logic [NL-1:0]    req,
  input  logic [NL-1:0]    st_therm,
  output logic [NL-1:0]    rd_data
);
  logic [NL-1:0] grp_data;

  always_comb begin
    unique case (grp_e'(sel))
      GRP_PWR:   grp_data = st_pwr;
      GRP_OPEN:  grp_data = st_open;
      GRP_OVL:   grp_data = st_ovl;
      GRP_ACT:   grp_data = st_act;
      GRP_REQ:   grp_data = req;
      GRP_THERM: grp_data = st_therm;
      default:   grp_data = '0;
    endcase
    rd_data = addr ? grp_data : {hot, sel};
  end

  // R6: reserved codes give zero on a status read
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr && sel[2] && !sel[1]) |-> (rd_data == '0));
endmodule

// File: rtl/ifb_regport.sv
module ifb_regport
  import ifb_pkg::*;
#(
  parameter int NL = NUM_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          a0,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [NL-1:0] dq_in,
  output logic [NL-1:0] dq_out,
  output logic          dq_oe,
  input  logic          hot,
  input  logic [NL-1:0] st_pwr,
  input  logic [NL-1:0] st_open,
  input  logic [NL-1:0] st_ovl,
  input  logic [NL-1:0] st_act,
  input  logic [NL-1:0] st_therm,
  output logic [NL-1:0] req_en,
  output logic          int_n
);
  localparam int SW = 5 + NL;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, {NL{1'b0}}};

  logic             rst_s;
  logic [SW-1:0]    pin_s;
  logic             ale_s, a0_s, cs_n_s, rd_n_s, wr_n_s;
  logic [NL-1:0]    d_s;
  logic             addr_eff, rd_act, int_en;
  logic [SEL_W-1:0] sel;
  logic             int_n_q, int_n_d;

  ifb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  ifb_sync #(.W(SW), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     ({ale, a0, cs_n, rd_n, wr_n, dq_in}),
    .q     (pin_s)
  );

  assign {ale_s, a0_s, cs_n_s, rd_n_s, wr_n_s, d_s} = pin_s;

  ifb_decode #(.NL(NL)) u_dec (
    .clk      (clk),
    .rst_n    (rst_s),
    .ale_s    (ale_s),
    .a0_s     (a0_s),
    .cs_n_s   (cs_n_s),
    .rd_n_s   (rd_n_s),
    .wr_n_s   (wr_n_s),
    .d_s      (d_s),
    .addr_eff (addr_eff),
    .rd_act   (rd_act),
    .sel_q    (sel),
    .int_en_q (int_en),
    .req_q    (req_en)
  );

  ifb_rdmux #(.NL(NL)) u_mux (
    .clk      (clk),
    .rst_n    (rst_s),
    .addr     (addr_eff),
    .sel      (sel),
    .hot      (hot),
    .st_pwr   (st_pwr),
    .st_open  (st_open),
    .st_ovl   (st_ovl),
    .st_act   (st_act),
    .req      (req_en),
    .st_therm (st_therm),
    .rd_data  (dq_out)
  );

  assign dq_oe   = rd_act;
  assign int_n_d = !(int_en && (|st_ovl));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) int_n_q <= 1'b1;
    else        int_n_q <= int_n_d;
  end

  assign int_n = int_n_q;

  // R9: interrupt disabled means int_n high on the next cycle
  a_r9_disabled_high: assert property (@(posedge clk) disable iff (!rst_s)
    !int_en |=> int_n);

  // R9: no overload bit means int_n high on the next cycle
  a_r9_clear_high: assert property (@(posedge clk) disable iff (!rst_s)
    (st_ovl == '0) |=> int_n);

  // R7: released bus while chip select is high
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n_s |-> !dq_oe);
endmodule

// File: tb/tb_ifb_regport.sv
`timescale 1ns/1ps
module tb_ifb_regport;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ale, a0, cs_n, rd_n, wr_n;
  logic [3:0] dq_in;
  logic [3:0] dq_out;
  logic       dq_oe;
  logic       hot;
  logic [3:0] st_pwr, st_open, st_ovl, st_act, st_therm;
  logic [3:0] req_en;
  logic       int_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ifb_regport dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .a0(a0), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .hot(hot),
    .st_pwr(st_pwr), .st_open(st_open), .st_ovl(st_ovl), .st_act(st_act),
    .st_therm(st_therm), .req_en(req_en), .int_n(int_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic adr, input logic [3:0] dat);
    @(negedge clk);
    a0 = adr; dq_in = dat;
    cyc(3);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(4);
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic bus_read(input logic adr, output logic [3:0] dat, output logic oe);
    @(negedge clk);
    a0 = adr;
    cyc(3);
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(4);
    dat = dq_out; oe = dq_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset;
    chk("R1 req_en", {4'h0, req_en}, 8'h00);
    chk("R1 int_n", {7'h0, int_n}, 8'h01);
    chk("R1 dq_oe", {7'h0, dq_oe}, 8'h00);
    begin
      logic [3:0] d; logic oe;
      bus_read(1'b0, d, oe);
      chk("R1 selector reads 0", {4'h0, d}, 8'h00);
    end
  endtask

  task automatic t_req_write;
    bus_write(1'b1, 4'b1010);
    chk("R3 req write 1010", {4'h0, req_en}, 8'h0a);
    bus_write(1'b1, 4'b0101);
    chk("R3 req write 0101", {4'h0, req_en}, 8'h05);
  endtask

  task automatic t_sel_rw;
    logic [3:0] d; logic oe;
    hot = 1'b0;
    bus_write(1'b0, 4'b1010);
    bus_read(1'b0, d, oe);
    chk("R4 sel read hot=0", {4'h0, d}, 8'h02);
    chk("R7 oe during read", {7'h0, oe}, 8'h01);
    hot = 1'b1;
    bus_read(1'b0, d, oe);
    chk("R4 sel read hot=1", {4'h0, d}, 8'h0a);
    hot = 1'b0;
    bus_write(1'b0, 4'b0011);
  endtask

  task automatic t_groups;
    logic [3:0] d; logic oe;
    logic [3:0] exp_t [8];
    exp_t[0] = st_pwr; exp_t[1] = st_open; exp_t[2] = st_ovl; exp_t[3] = st_act;
    exp_t[4] = 4'h0;   exp_t[5] = 4'h0;    exp_t[6] = req_en; exp_t[7] = st_therm;
    for (int c = 0; c < 8; c++) begin
      bus_write(1'b0, {1'b0, 3'(c)});
      bus_read(1'b1, d, oe);
      if (c == 4 || c == 5) chk($sformatf("R6 reserved code %0d", c), {4'h0, d}, {4'h0, exp_t[c]});
      else                  chk($sformatf("R5 group code %0d", c), {4'h0, d}, {4'h0, exp_t[c]});
    end
  endtask

  task automatic t_latch;
    logic [3:0] d; logic oe;
    bus_write(1'b0, 4'b0001);
    @(negedge clk);
    a0 = 1'b1; ale = 1'b1;
    cyc(3);
    ale = 1'b0;
    cyc(4);
    a0 = 1'b0;
    cyc(3);
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(4);
    d = dq_out;
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(4);
    chk("R8 latched a0=1 gives status group", {4'h0, d}, {4'h0, st_open});
    ale = 1'b1;
    cyc(4);
    bus_read(1'b0, d, oe);
    chk("R8 transparent a0=0 gives selector", {4'h0, d}, 8'h01);
  endtask

  task automatic t_int;
    bus_write(1'b0, 4'b0000);
    st_ovl = 4'b0100;
    cyc(3);
    chk("R9 disabled keeps int_n high", {7'h0, int_n}, 8'h01);
    bus_write(1'b0, 4'b1000);
    chk("R9 enabled with overload", {7'h0, int_n}, 8'h00);
    st_ovl = 4'b0000;
    @(negedge clk);
    chk("R9 releases one clock after clear", {7'h0, int_n}, 8'h01);
    st_ovl = 4'b0001;
    @(negedge clk);
    chk("R9 reasserts, unlatched", {7'h0, int_n}, 8'h00);
    st_ovl = 4'b0000;
    cyc(2);
    bus_write(1'b0, 4'b0000);
  endtask

  task automatic t_ignored;
    @(negedge clk);
    a0 = 1'b1; dq_in = 4'b1111;
    cyc(3);
    wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(4);
    chk("R10 write without cs ignored", {4'h0, req_en}, 8'h05);
    chk("R7 no drive without cs", {7'h0, dq_oe}, 8'h00);
  endtask

  task automatic t_cs_first;
    @(negedge clk);
    a0 = 1'b1; dq_in = 4'b0110;
    cyc(3);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(4);
    cs_n = 1'b1;
    cyc(4);
    chk("R2 commit on cs_n rising first", {4'h0, req_en}, 8'h06);
    dq_in = 4'b1001;
    cyc(2);
    wr_n = 1'b1;
    cyc(4);
    chk("R2 later wr_n rise no second commit", {4'h0, req_en}, 8'h06);
  endtask

  initial begin
    rst_n = 1'b0; ale = 1'b1; a0 = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    dq_in = 4'h0; hot = 1'b0;
    st_pwr = 4'h9; st_open = 4'h6; st_ovl = 4'h0; st_act = 4'hc; st_therm = 4'h5;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    t_reset;
    t_req_write;
    t_sel_rw;
    t_groups;
    t_latch;
    t_int;
    t_ignored;
    t_cs_first;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule